// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt of a real-time-clock timebase. A 14-stage binary divider advances once for each pulse of a 32.768 kHz tick enable that is synchronous to the system clock. A four-bit rate code selects one divider stage. Each time that stage's count wraps, a periodic flag is set. When the interrupt enable is set, the flag drives an active-low interrupt line.

Software programs three fields through separate write strobes: the rate code, a three-bit divider-control code and the enable bit. A divider-control code can hold the whole chain at zero, so software can restart the timebase from a known phase. A status read returns the flag and clears it in the same access. A new flag event that lands on the clearing read wins, so no interrupt is lost.

Rate codes 3 to 15 give periods of 2^(code-1) ticks, from 4 ticks (8.192 kHz) up to 16384 ticks (2 Hz). Codes 1 and 2 repeat the 128-tick and 256-tick rates of codes 8 and 9. Code 0 disables the flag.

Top module: `pi_rate_gen`

## Requirements
- R1: A synchronous active-high reset clears the flag (`pf_o`=0), drives `irq_n` high, clears the enable, sets the rate code to 0 and sets the divider-control code to 3'b010 (run).
- R2: With rate code c in 3..15 (written on `rate_wdata[3:0]`), the flag is set once every 2^(c-1) ticks. After the divider is released from hold, the first set comes on the 2^(c-1)-th tick.
- R3: Rate code 1 sets the flag every 128 ticks and rate code 2 every 256 ticks. These match codes 8 and 9.
- R4: Rate code 0 never sets the flag.
- R5: The flag is set at the selected rate whether or not the enable is set. While the enable is 1 and the flag is 1, `irq_n` is low in the same cycle that `pf_o` shows the flag.
- R6: While the enable is 0, `irq_n` stays high whatever the flag does.
- R7: Divider-control codes 3'b110 and 3'b111 hold every divider stage at zero, and no flag is set while held.
- R8: Any divider-control code other than 3'b110 and 3'b111 lets the divider count. 3'b010 is normal operation and the remaining codes are test modes with the same counting.
- R9: A `stat_rd` strobe clears the flag at the clock edge where it is seen. Without a read, the flag stays set.
- R10: If a flag event falls on the same edge as a `stat_rd` strobe, the flag remains set.
- R11: Writing a new rate code does not reset the divider. The new rate takes effect at its next stage wrap from the current count.
- R12: The divider advances only on cycles where `tick_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle 32.768 kHz tick enable |
| rate_we | input | 1 | Write strobe for the rate code |
| rate_wdata | input | 4 | Rate code to write |
| divc_we | input | 1 | Write strobe for the divider-control code |
| divc_wdata | input | 3 | Divider-control code to write |
| pie_we | input | 1 | Write strobe for the interrupt enable |
| pie_wdata | input | 1 | Interrupt enable value to write |
| stat_rd | input | 1 | Status read strobe that clears the flag |
| pf_o | output | 1 | Periodic flag, the status read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
A wrong divider count, an off-by-one stage selection or a lost wrap shows at `pf_o` as a flag at the wrong distance from the previous one. The error appears one selected period after the fault at the latest: 4 ticks for the fastest code, 16384 for the slowest. A wrong flag or enable register shows at `irq_n` on the very next edge, because the bench compares both outputs against its model on every clock. A divider that restarts on a rate change shifts the first flag after the change by a measurable number of edges.

// File: rtl/pi_pkg.sv
package pi_pkg;
  localparam int DIVC_W = 3;

  typedef enum logic [1:0] {DM_RUN, DM_TEST, DM_HOLD} div_mode_e;

  function automatic div_mode_e div_mode(input logic [DIVC_W-1:0] code);
    case (code)
      3'b110, 3'b111: div_mode = DM_HOLD;
      3'b010:         div_mode = DM_RUN;
      default:        div_mode = DM_TEST;
    endcase
  endfunction

  // number of divider stages whose joint wrap marks one period; 0 = none
  function automatic int tap_len(input int code, input int alias_base);
    if (code == 0)      tap_len = 0;
    else if (code == 1) tap_len = alias_base;
    else if (code == 2) tap_len = alias_base + 1;
    else                tap_len = code - 1;
  endfunction
endpackage

// File: rtl/pi_ctrl_regs.sv
module pi_ctrl_regs #(
  parameter int RATE_W = 4,
  parameter logic [pi_pkg::DIVC_W-1:0] DIVC_RST = 3'b010
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rate_we,
  input  logic [RATE_W-1:0]         rate_wdata,
  input  logic                      divc_we,
  input  logic [pi_pkg::DIVC_W-1:0] divc_wdata,
  input  logic                      pie_we,
  input  logic                      pie_wdata,
  output logic [RATE_W-1:0]         rate_q,
  output logic [pi_pkg::DIVC_W-1:0] div_q,
  output logic                      pie_q,
  output logic                      pie_nxt
);
  assign pie_nxt = pie_we ? pie_wdata : pie_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= '0;
      div_q  <= DIVC_RST;
      pie_q  <= 1'b0;
    end else begin
      if (rate_we) rate_q <= rate_wdata;
      if (divc_we) div_q  <= divc_wdata;
      pie_q <= pie_nxt;
    end
  end
endmodule

// File: rtl/pi_divider.sv
module pi_divider #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             step,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst || hold) cnt_q <= '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pi_tap_sel.sv
module pi_tap_sel #(
  parameter int CNT_W      = 14,
  parameter int RATE_W     = 4,
  parameter int ALIAS_BASE = 7
) (
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              step,
  input  logic [RATE_W-1:0] rate_q,
  output logic              tap_ev
);
  localparam int N_CODES = 1 << RATE_W;

  logic [N_CODES-1:0] wrap_vec;

  for (genvar c = 0; c < N_CODES; c++) begin : g_code
    localparam int LEN = pi_pkg::tap_len(c, ALIAS_BASE);
    if (LEN > 0 && LEN <= CNT_W) begin : g_live
      assign wrap_vec[c] = step & (&cnt_q[LEN-1:0]);
    end else begin : g_off
      assign wrap_vec[c] = 1'b0;
    end
  end

  assign tap_ev = wrap_vec[rate_q];
endmodule

// File: rtl/pi_flag_irq.sv
module pi_flag_irq (
  input  logic clk,
  input  logic rst,
  input  logic tap_ev,
  input  logic stat_rd,
  input  logic pie_nxt,
  output logic pf_o,
  output logic irq_n
);
  logic pf_d;

  assign pf_d = tap_ev | (pf_o & ~stat_rd);

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_o  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      pf_o  <= pf_d;
      irq_n <= ~(pf_d & pie_nxt);
    end
  end
endmodule

// File: rtl/pi_rate_gen.sv
module pi_rate_gen #(
  parameter int CNT_W      = 14,
  parameter int RATE_W     = 4,
  parameter int ALIAS_BASE = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      tick_en,
  input  logic                      rate_we,
  input  logic [RATE_W-1:0]         rate_wdata,
  input  logic                      divc_we,
  input  logic [pi_pkg::DIVC_W-1:0] divc_wdata,
  input  logic                      pie_we,
  input  logic                      pie_wdata,
  input  logic                      stat_rd,
  output logic                      pf_o,
  output logic                      irq_n
);
  logic [RATE_W-1:0]         rate_q;
  logic [pi_pkg::DIVC_W-1:0] div_q;
  logic                      pie_q;
  logic                      pie_nxt;
  logic                      hold;
  logic                      step;
  logic [CNT_W-1:0]          cnt_q;
  logic                      tap_ev;

  pi_ctrl_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst(rst),
    .rate_we(rate_we), .rate_wdata(rate_wdata),
    .divc_we(divc_we), .divc_wdata(divc_wdata),
    .pie_we(pie_we), .pie_wdata(pie_wdata),
    .rate_q(rate_q), .div_q(div_q), .pie_q(pie_q), .pie_nxt(pie_nxt)
  );

  assign hold = (pi_pkg::div_mode(div_q) == pi_pkg::DM_HOLD);
  assign step = tick_en & ~hold;

  pi_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .hold(hold), .step(step), .cnt_q(cnt_q)
  );

  pi_tap_sel #(.CNT_W(CNT_W), .RATE_W(RATE_W), .ALIAS_BASE(ALIAS_BASE)) u_tap (
    .cnt_q(cnt_q), .step(step), .rate_q(rate_q), .tap_ev(tap_ev)
  );

  pi_flag_irq u_flag (
    .clk(clk), .rst(rst), .tap_ev(tap_ev), .stat_rd(stat_rd),
    .pie_nxt(pie_nxt), .pf_o(pf_o), .irq_n(irq_n)
  );
endmodule

// File: rtl/pi_rate_gen_chk.sv
module pi_rate_gen_chk #(
  parameter int CNT_W  = 14,
  parameter int RATE_W = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      tick_en,
  input logic                      stat_rd,
  input logic                      pf_o,
  input logic                      irq_n,
  input logic                      pie_q,
  input logic [RATE_W-1:0]         rate_q,
  input logic [pi_pkg::DIVC_W-1:0] div_q,
  input logic [CNT_W-1:0]          cnt_q
);
  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    !pie_q |-> irq_n);

  p_irq_drive_r5: assert property (@(posedge clk) disable iff (rst)
    (pie_q && pf_o) |-> !irq_n);

  p_hold_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (div_q[2:1] == 2'b11) |=> (cnt_q == '0));

  p_flag_source_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(pf_o) |-> ($past(rate_q) != '0 && $past(tick_en) && $past(div_q[2:1]) != 2'b11));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !tick_en) |=> !pf_o);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (pf_o && !stat_rd) |=> pf_o);

  p_idle_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && div_q[2:1] != 2'b11) |=> $stable(cnt_q));
endmodule

bind pi_rate_gen pi_rate_gen_chk #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .stat_rd(stat_rd),
  .pf_o(pf_o), .irq_n(irq_n), .pie_q(pie_q), .rate_q(rate_q),
  .div_q(div_q), .cnt_q(cnt_q)
);

// File: tb/sim_pi_rate_gen.sv
`timescale 1ns/1ps
module sim_pi_rate_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b1;
  logic       rate_we = 1'b0;
  logic [3:0] rate_wdata = '0;
  logic       divc_we = 1'b0;
  logic [2:0] divc_wdata = '0;
  logic       pie_we = 1'b0;
  logic       pie_wdata = 1'b0;
  logic       stat_rd = 1'b0;
  logic       pf_o;
  logic       irq_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 1'b0;

  always #2.5 clk = ~clk;

  pi_rate_gen u0 (
    .clk(clk), .rst(rst), .tick_en(tick_en),
    .rate_we(rate_we), .rate_wdata(rate_wdata),
    .divc_we(divc_we), .divc_wdata(divc_wdata),
    .pie_we(pie_we), .pie_wdata(pie_wdata),
    .stat_rd(stat_rd), .pf_o(pf_o), .irq_n(irq_n)
  );

  // behavioural reference model
  int m_cnt, m_rate, m_div, m_pie, m_pf;

  function automatic int period_of(int code);
    case (code)
      0: return 0;
      1: return 128;
      2: return 256;
      default: return 1 << (code - 1);
    endcase
  endfunction

  always @(posedge clk) begin
    int ev;
    started = 1'b1;
    cyc++;
    if (rst) begin
      m_cnt = 0; m_rate = 0; m_div = 2; m_pie = 0; m_pf = 0;
    end else begin
      ev = 0;
      if (m_div == 6 || m_div == 7) m_cnt = 0;
      else if (tick_en) begin
        if (period_of(m_rate) > 0 && ((m_cnt + 1) % period_of(m_rate)) == 0) ev = 1;
        m_cnt = (m_cnt + 1) % 16384;
      end
      m_pf = (ev != 0 || (m_pf != 0 && !stat_rd)) ? 1 : 0;
      if (rate_we) m_rate = int'(rate_wdata);
      if (divc_we) m_div = int'(divc_wdata);
      if (pie_we) m_pie = int'(pie_wdata);
    end
  end

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check("R2 model pf_o", int'(pf_o), m_pf);
      check("R5 model irq_n", int'(irq_n), (m_pf != 0 && m_pie != 0) ? 0 : 1);
    end
  end

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected below 190000", cyc);
      finish_sim();
    end
  end

  task automatic wr_rate(int code);
    rate_we = 1'b1; rate_wdata = 4'(code);
    @(negedge clk); rate_we = 1'b0;
  endtask

  task automatic wr_div(int code);
    divc_we = 1'b1; divc_wdata = 3'(code);
    @(negedge clk); divc_we = 1'b0;
  endtask

  task automatic wr_pie(bit v);
    pie_we = 1'b1; pie_wdata = v;
    @(negedge clk); pie_we = 1'b0;
  endtask

  task automatic count_pf(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (pf_o) c++;
    end
  endtask

  // hold divider, load rate, release with given code; returns at negedge after release edge
  task automatic restart(int code, int rel);
    wr_div(6);
    wr_rate(code);
    wr_div(rel);
  endtask

  initial begin
    int c, c8;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pf_o after reset", int'(pf_o), 0);
    check("R1 irq_n after reset", int'(irq_n), 1);

    // R2: every doubling rate, read each cycle so each event is one pf pulse
    stat_rd = 1'b1;
    for (int code = 3; code <= 15; code++) begin
      restart(code, 2);
      count_pf(2 * (1 << (code - 1)) + 1, c);
      check($sformatf("R2 pulses code %0d", code), c, 2);
    end

    // R3: aliased codes against codes 8 and 9
    restart(1, 2); count_pf(2 * 128 + 1, c);
    restart(8, 2); count_pf(2 * 128 + 1, c8);
    check("R3 code 1 pulses", c, 2);
    check("R3 code 1 equals code 8", c, c8);
    restart(2, 2); count_pf(2 * 256 + 1, c);
    check("R3 code 2 pulses", c, 2);
    restart(2, 2); count_pf(255, c);
    check("R3 code 2 none before 256 ticks", c, 0);

    // R4: code 0 gives no flag
    restart(0, 2); count_pf(4096, c);
    check("R4 code 0 pulses", c, 0);

    // R8: test-mode divider codes still count
    restart(4, 0); count_pf(17, c);
    check("R8 test code 000 pulses", c, 2);
    restart(4, 5); count_pf(17, c);
    check("R8 test code 101 pulses", c, 2);

    // R7: hold codes freeze the chain
    restart(3, 2);
    wr_div(6); count_pf(40, c);
    check("R7 hold 110 pulses", c, 0);
    wr_div(7); count_pf(40, c);
    check("R7 hold 111 pulses", c, 0);

    // R12: no ticks, no advance
    wr_div(2);
    tick_en = 1'b0;
    count_pf(60, c);
    check("R12 idle ticks pulses", c, 0);
    tick_en = 1'b1;

    // R5 / R6: flag independent of enable, enable gates irq_n
    stat_rd = 1'b0;
    restart(3, 2);
    c = 0;
    while (!pf_o && c < 20) begin @(negedge clk); c++; end
    check("R5 flag sets with enable off", int'(pf_o), 1);
    check("R6 irq_n high with enable off", int'(irq_n), 1);
    wr_pie(1'b1);
    check("R5 irq_n low once enabled", int'(irq_n), 0);
    wr_pie(1'b0);
    check("R6 irq_n high after disable", int'(irq_n), 1);
    wr_pie(1'b1);

    // R9 / R10: sticky flag, collision, clear
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    restart(3, 2);
    c = 0;
    while (!pf_o && c < 20) begin @(negedge clk); c++; end
    repeat (3) @(negedge clk);
    check("R9 flag held without read", int'(pf_o), 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;   // edge carries a new event
    check("R10 flag kept on collision", int'(pf_o), 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    check("R9 flag cleared by read", int'(pf_o), 0);
    check("R9 irq_n released by read", int'(irq_n), 1);

    // R11: divider at 101 after write edge; next 16-wrap (111->112) is 11 edges on
    stat_rd = 1'b1;
    restart(3, 2);
    repeat (100) @(negedge clk);
    wr_rate(5);
    c = 0;
    for (int j = 1; j <= 20; j++) begin
      @(negedge clk);
      if (pf_o && c == 0) c = j;
    end
    check("R11 first flag after rate change", c, 11);

    // mixed traffic against the model
    for (int k = 0; k < 3000; k++) begin
      tick_en = 1'($urandom_range(0, 1));
      stat_rd = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 199) == 0) begin
        rate_we = 1'b1; rate_wdata = 4'($urandom_range(0, 6));
      end
      if ($urandom_range(0, 99) == 0) begin
        pie_we = 1'b1; pie_wdata = 1'($urandom_range(0, 1));
      end
      @(negedge clk);
      rate_we = 1'b0; pie_we = 1'b0;
    end
    tick_en = 1'b1; stat_rd = 1'b0;
    repeat (4) @(negedge clk);
    finish_sim();
  end
endmodule